// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

This block is a shared word memory with two fully independent access ports, left and right. Each port has its own clock and captures its select pair, read/write strobe, address and write data on the rising edge. A write is committed to the array on the following edge of the same port, so a read issued on the next edge of either port returns the new word. Each port has its own static latency select. In flow-through mode read data appears in the cycle that follows the capturing edge. In pipelined mode it appears one cycle later.

The output buffer is modelled by a drive flag and a data bus. While the flag is low, the bus reads as zero. The active-low output enable gates the buffer combinationally, with no clock involved. Whether the buffer drives in a cycle depends only on the controls captured at the previous edge.

In pipelined mode each port runs a small output state machine with three states:
- `OUT_IDLE`: the port was deselected.
- `OUT_WARM`: one selected cycle has been seen.
- `OUT_LIVE`: the outputs may drive.

The transitions are:
- A selected capture moves `OUT_IDLE` to `OUT_WARM`, `OUT_WARM` to `OUT_LIVE`, and holds `OUT_LIVE`.
- A deselected capture returns any state to `OUT_IDLE`.

As a result, two consecutive selected edges are needed before pipelined data is shown again. The array is stored as two banks, one written by each port, and the stored word is the XOR of the two banks. When both ports write the same address, the left port wins and a one-cycle collision flag is raised. This rule assumes that both ports share one clock.

Top module: `dpr_core`

## Requirements
- R1: A port is selected only when its select-low input is 0 and its select-high input is 1 at the capturing edge. A deselected capture performs no write, and in flow-through mode the port does not drive in the following cycle.
- R2: A selected capture with read/write = 0 stores the write data at the captured address, and the word is readable from the next edge of either port.
- R3: While output enable (active low) is 1, the drive flag is 0 and the data bus is 0 at once, whatever the clock is doing.
- R4: In flow-through mode, a selected capture with read/write = 1 drives the addressed word during the cycle that follows that edge.
- R5: In pipelined mode the same read is driven one cycle later than in flow-through mode.
- R6: In pipelined mode, a read is shown only if the port was also selected at the edge before it. After a deselect, the first selected read is not shown.
- R7: If one port writes an address and the other port reads it at the same edge, the read returns the old word, and reads from the next edge return the new word.
- R8: If both ports write the same address at the same edge, the left data is stored, and the collision flag is 1 for the one left-clock cycle after the commit edge.
- R9: After reset, both drive flags and the collision flag are 0, and both output state machines are in `OUT_IDLE`.
- R10: The latency select of each port is independent, so one port can run flow-through while the other runs pipelined.
- R11: While a port is not driving, its data bus reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| r_clk | input | 1 | Right port clock |
| rst_n | input | 1 | Active-low reset for both ports |
| l_en_n | input | 1 | Left select, active low |
| l_en | input | 1 | Left select, active high |
| l_rd_wr | input | 1 | Left: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low, unclocked |
| l_pipe | input | 1 | Left latency select: 1 pipelined, 0 flow-through (static) |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data (zero when not driven) |
| l_drive | output | 1 | Left output buffer driving |
| r_en_n | input | 1 | Right select, active low |
| r_en | input | 1 | Right select, active high |
| r_rd_wr | input | 1 | Right: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low, unclocked |
| r_pipe | input | 1 | Right latency select (static) |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data (zero when not driven) |
| r_drive | output | 1 | Right output buffer driving |
| collide | output | 1 | Same-address double write seen (left clock domain) |

## Verification
The bench runs the left port in flow-through mode and the right port in pipelined mode from one clock, and compares every cycle against a reference word model. It targets four corner cases:
- A select pattern that alternates with deselects. A core without reactivation gating would show the orphan pipelined reads.
- A write on one port with a read of the same address on the other port at the same edge. A core that commits at the capture edge would return the new word one cycle early.
- A double write to the same address. A core that resolves it the wrong way would keep the right data or leave the collision flag low.
- Output enable toggled in the middle of a cycle. A registered enable would keep the bus driven until the next edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    // Output activation states used by each port in pipelined mode
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_WARM = 2'd1,
        OUT_LIVE = 2'd2
    } out_state_e;
endpackage

// File: rtl/dpr_bank.sv
// One storage bank, written by exactly one port, read at three addresses.
module dpr_bank #(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wword,
    input  logic [AW-1:0] ra_l,
    input  logic [AW-1:0] ra_r,
    input  logic [AW-1:0] ra_x,
    output logic [DW-1:0] rd_l,
    output logic [DW-1:0] rd_r,
    output logic [DW-1:0] rd_x
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wword;
    end

    assign rd_l = cells[ra_l];
    assign rd_r = cells[ra_r];
    assign rd_x = cells[ra_x];
endmodule

// File: rtl/dpr_port.sv
// Input capture, output activation state machine and output buffer of one port.
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          en,
    input  logic          rd_wr,
    input  logic          oe_n,
    input  logic          pipe,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_word,
    output logic          wr_req,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] dout,
    output logic          drive
);
    logic          sel_now;
    logic          sel_q, rd_q, wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          pipe_rd;
    logic [DW-1:0] pipe_dat;
    out_state_e    state, state_nx;

    assign sel_now = !en_n && en;

    // State and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            rd_q     <= 1'b0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            pipe_rd  <= 1'b0;
            pipe_dat <= '0;
            state    <= OUT_IDLE;
        end else begin
            sel_q    <= sel_now;
            rd_q     <= sel_now && rd_wr;
            wr_q     <= sel_now && !rd_wr;
            addr_q   <= addr;
            data_q   <= wdata;
            pipe_rd  <= rd_q;
            pipe_dat <= rd_word;
            state    <= state_nx;
        end
    end

    // Next-state logic of the activation machine
    always_comb begin
        state_nx = OUT_IDLE;
        unique case (state)
            OUT_IDLE: state_nx = sel_q ? OUT_WARM : OUT_IDLE;
            OUT_WARM: state_nx = sel_q ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_nx = sel_q ? OUT_LIVE : OUT_IDLE;
            default:  state_nx = OUT_IDLE;
        endcase
    end

    // Output buffer: the enable acts without a clock
    always_comb begin
        if (oe_n)
            drive = 1'b0;
        else if (pipe)
            drive = pipe_rd && (state == OUT_LIVE);
        else
            drive = rd_q;
        dout = drive ? (pipe ? pipe_dat : rd_word) : '0;
    end

    assign wr_req   = wr_q;
    assign acc_addr = addr_q;
    assign wr_data  = data_q;

    // Checker: cycles since reset, saturating
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r3_oe_floats: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drive && dout == '0));

    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && age != 2'd0 && $past(!(!en_n && en))) |-> !drive);

    a_r4_flow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && age != 2'd0 && !oe_n && $past(!en_n && en && rd_wr))
            |-> (drive && dout == rd_word));

    a_r6_pipe_reactivate: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && age == 2'd3 && $past(!(!en_n && en), 2)) |-> !drive);
endmodule

// File: rtl/dpr_core.sv
// Two-port word memory: left and right ports over two XOR-combined banks.
module dpr_core #(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          l_clk,
    input  logic          r_clk,
    input  logic          rst_n,
    input  logic          l_en_n,
    input  logic          l_en,
    input  logic          l_rd_wr,
    input  logic          l_oe_n,
    input  logic          l_pipe,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_drive,
    input  logic          r_en_n,
    input  logic          r_en,
    input  logic          r_rd_wr,
    input  logic          r_oe_n,
    input  logic          r_pipe,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_drive,
    output logic          collide
);
    localparam int NP = 2;

    logic          clk_p [NP];
    logic          wreq  [NP];
    logic          blk   [NP];
    logic [AW-1:0] aaddr [NP];
    logic [DW-1:0] wdat  [NP];
    logic [DW-1:0] rd_l_b [NP];
    logic [DW-1:0] rd_r_b [NP];
    logic [DW-1:0] rd_x_b [NP];
    logic [DW-1:0] word_l, word_r;

    assign clk_p[0] = l_clk;
    assign clk_p[1] = r_clk;

    // Left wins a same-address double write: the right commit is held back
    assign blk[0] = 1'b0;
    assign blk[1] = wreq[0] && wreq[1] && (aaddr[0] == aaddr[1]);

    assign word_l = rd_l_b[0] ^ rd_l_b[1];
    assign word_r = rd_r_b[0] ^ rd_r_b[1];

    dpr_port #(.AW(AW), .DW(DW)) u_left (
        .clk(l_clk), .rst_n(rst_n), .en_n(l_en_n), .en(l_en), .rd_wr(l_rd_wr),
        .oe_n(l_oe_n), .pipe(l_pipe), .addr(l_addr), .wdata(l_wdata),
        .rd_word(word_l), .wr_req(wreq[0]), .acc_addr(aaddr[0]),
        .wr_data(wdat[0]), .dout(l_rdata), .drive(l_drive)
    );

    dpr_port #(.AW(AW), .DW(DW)) u_right (
        .clk(r_clk), .rst_n(rst_n), .en_n(r_en_n), .en(r_en), .rd_wr(r_rd_wr),
        .oe_n(r_oe_n), .pipe(r_pipe), .addr(r_addr), .wdata(r_wdata),
        .rd_word(word_r), .wr_req(wreq[1]), .acc_addr(aaddr[1]),
        .wr_data(wdat[1]), .dout(r_rdata), .drive(r_drive)
    );

    // Bank g is written only by port g; it stores data XOR the other bank
    for (genvar g = 0; g < NP; g++) begin : g_bank
        localparam int OTHER = NP - 1 - g;
        dpr_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk(clk_p[g]),
            .we(wreq[g] && !blk[g]),
            .waddr(aaddr[g]),
            .wword(wdat[g] ^ rd_x_b[OTHER]),
            .ra_l(aaddr[0]),
            .ra_r(aaddr[1]),
            .ra_x(aaddr[OTHER]),
            .rd_l(rd_l_b[g]),
            .rd_r(rd_r_b[g]),
            .rd_x(rd_x_b[g])
        );
    end

    always_ff @(posedge l_clk) begin
        if (!rst_n) collide <= 1'b0;
        else        collide <= blk[1];
    end
endmodule

// File: tb/tb_dpr_core.sv
module tb_dpr_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en_n = 1'b1, l_en = 1'b0, l_rd_wr = 1'b1, l_oe_n = 1'b0;
    logic r_en_n = 1'b1, r_en = 1'b0, r_rd_wr = 1'b1, r_oe_n = 1'b0;
    logic l_pipe = 1'b0, r_pipe = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_drive, r_drive, collide;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_core #(.AW(AW), .DW(DW)) dut (
        .l_clk(clk), .r_clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_en(l_en), .l_rd_wr(l_rd_wr), .l_oe_n(l_oe_n),
        .l_pipe(l_pipe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_drive(l_drive),
        .r_en_n(r_en_n), .r_en(r_en), .r_rd_wr(r_rd_wr), .r_oe_n(r_oe_n),
        .r_pipe(r_pipe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_drive(r_drive), .collide(collide)
    );

    typedef struct {
        int            due;
        bit            drv;
        logic [DW-1:0] dat;
        string         req;
    } exp_t;

    exp_t ql[$];
    exp_t qr[$];
    exp_t qc[$];
    exp_t it;
    logic [DW-1:0] mdl [1 << AW];
    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  r_prev = 1'b0;
    bit  done = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: set both ports for the next edge and push the expected results
    task automatic step(input bit len_n, input bit len, input bit lrw,
                        input int la, input int ld,
                        input bit ren_n, input bit ren, input bit rrw,
                        input int ra, input int rd,
                        input string tag, input bit lchk = 1'b1);
        int  e;
        bit  lsel, rsel, lrd, rrd, col;
        exp_t x;
        @(negedge clk);
        l_en_n = len_n; l_en = len; l_rd_wr = lrw; l_addr = la[AW-1:0]; l_wdata = ld[DW-1:0];
        r_en_n = ren_n; r_en = ren; r_rd_wr = rrw; r_addr = ra[AW-1:0]; r_wdata = rd[DW-1:0];
        e    = cyc + 1;
        lsel = !len_n && len;
        rsel = !ren_n && ren;
        lrd  = lsel && lrw;
        rrd  = rsel && rrw && r_prev;
        if (lchk) begin
            x.due = e; x.drv = lrd; x.dat = lrd ? mdl[la] : '0; x.req = tag;
            ql.push_back(x);
        end
        x.due = e + 1; x.drv = rrd; x.dat = rrd ? mdl[ra] : '0; x.req = tag;
        qr.push_back(x);
        col = lsel && !lrw && rsel && !rrw && (la == ra);
        x.due = e + 1; x.drv = col; x.dat = '0; x.req = tag;
        qc.push_back(x);
        r_prev = rsel;
        if (rsel && !rrw) mdl[ra] = rd[DW-1:0];
        if (lsel && !lrw) mdl[la] = ld[DW-1:0];
    endtask

    // Monitor: compare at a quarter period after each edge
    always @(posedge clk) begin
        cyc++;
        #(CLK_PERIOD/4);
        while (ql.size() != 0 && ql[0].due == cyc) begin
            it = ql.pop_front();
            check(it.req, "left drive", int'(l_drive), int'(it.drv));
            check(it.req, "left data", int'(l_rdata), int'(it.dat));
        end
        while (qr.size() != 0 && qr[0].due == cyc) begin
            it = qr.pop_front();
            check(it.req, "right drive", int'(r_drive), int'(it.drv));
            check(it.req, "right data", int'(r_rdata), int'(it.dat));
        end
        while (qc.size() != 0 && qc[0].due == cyc) begin
            it = qc.pop_front();
            check(it.req, "collide", int'(collide), int'(it.drv));
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9", "left drive", int'(l_drive), 0);
        check("R9", "right drive", int'(r_drive), 0);
        check("R9", "collide", int'(collide), 0);

        // R2 left writes; R1 right select pair wrong, its write must not land
        for (int i = 0; i < 8; i++)
            step(0, 1, 0, 5 + i, (i * 37 + 3) & 511, 0, 0, 0, 5 + i, 9'h1ff, "R2 R1 R11");
        // Preload for cross-port cases; different-address double write (R8 no collide)
        step(0, 1, 0, 20, 9'h0aa, 0, 1, 0, 30, 9'h155, "R2 R8");
        step(0, 1, 0, 40, 9'h011, 1, 1, 0, 41, 9'h0ff, "R2 R1");

        // R4 flow stream on left, R5 pipelined stream on right (first one R6-dropped)
        for (int i = 0; i < 8; i++)
            step(0, 1, 1, 5 + i, 0, 0, 1, 1, 5 + i, 0, (i == 0) ? "R6" : "R4 R5 R10");

        // R6 pattern: deselect, lone select, deselect, two selects
        step(1, 0, 1, 5, 0, 1, 1, 1, 5, 0, "R6 R1");
        step(1, 0, 1, 5, 0, 0, 1, 1, 5, 0, "R6");
        step(1, 0, 1, 5, 0, 0, 0, 1, 6, 0, "R6");
        step(1, 0, 1, 5, 0, 0, 1, 1, 6, 0, "R6");
        step(1, 0, 1, 5, 0, 0, 1, 1, 7, 0, "R6");

        // R7 cross-port same-edge write/read in both directions
        step(0, 1, 0, 20, 9'h0f0, 0, 1, 1, 20, 0, "R7");
        step(1, 1, 1, 0, 0, 0, 1, 1, 20, 0, "R7");
        step(0, 1, 1, 30, 0, 0, 1, 0, 30, 9'h1e1, "R7");
        step(0, 1, 1, 30, 0, 0, 1, 1, 20, 0, "R7");

        // R8 same-address double write, then read back on both ports
        step(0, 1, 0, 40, 9'h0c3, 0, 1, 0, 40, 9'h13c, "R8");
        step(0, 1, 1, 40, 0, 0, 1, 1, 40, 0, "R8");
        step(0, 1, 1, 40, 0, 0, 1, 1, 40, 0, "R8");

        // R3 output enable acts inside a cycle
        step(0, 1, 1, 6, 0, 1, 0, 1, 0, 0, "R1", 1'b0);
        @(posedge clk);
        #(CLK_PERIOD/4 + 1);
        check("R4", "left drive before oe", int'(l_drive), 1);
        check("R4", "left data before oe", int'(l_rdata), int'(mdl[6]));
        l_oe_n = 1'b1;
        #1;
        check("R3", "left drive oe high", int'(l_drive), 0);
        check("R3", "left data oe high", int'(l_rdata), 0);
        l_oe_n = 1'b0;
        #1;
        check("R3", "left drive oe low again", int'(l_drive), 1);

        for (int i = 0; i < 3; i++)
            step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 R11");
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        check("R1", "queues drained", ql.size() + qr.size() + qc.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule